// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a serial nonvolatile memory that sits on a three-wire bus. The bus has a select line, a serial clock and a data-in line. The block returns data on a single data-out line with a separate output enable. A register array stands in for the cells. All three bus inputs are synchronized into the system clock domain. A serial clock rising edge is recognised there as an event.

A transaction starts with a start bit. Next come a two-bit opcode and an address field. A data word follows for the two write-type instructions. Read returns a leading zero and then the addressed word, most significant bit first. It keeps streaming the following words for as long as the clock runs. Programming instructions start a self-timed busy period counted in system clocks. The master can poll completion by dropping and raising select, which puts a ready/busy level on data out. One parameter picks the organization: byte mode has 128 words of 8 bits, and word mode has 64 words of 16 bits.

Top module: `eep_slave`

## Requirements
- R1: While select is high, the first serial-clock rising edge with data-in high is the start bit. Rising edges with data-in low before it change nothing.
- R2: In byte mode an instruction needs the start bit, 2 opcode bits and 7 address bits, plus 8 data bits for the write-type instructions (10 or 18 edges in all). A write cut short by dropping select stores nothing.
- R3: Opcode 10 is read. After the last address bit, data out is enabled and shows 0. Each later edge shifts out one data bit, MSB first. Data out is enabled only during a read or during status.
- R4: After the last bit of a word, a read continues with the next address. It wraps from the top address to 0.
- R5: Opcode 00 with address MSBs 11 enables programming, and 00 with address MSBs 00 disables it. The enable latch starts disabled after reset and is not cleared by select going low. Programming instructions issued while disabled change no word and start no busy period.
- R6: Opcode 01 writes the data word to the address. Opcode 11 sets the addressed word to all ones. Opcode 00 with address MSBs 10 sets every word to all ones. The array is all ones after reset.
- R7: Opcode 00 with address MSBs 01 writes the data word into every word, erasing first. Its busy period is twice that of a single write.
- R8: After a programming instruction has started, dropping and raising select enables data out with the value 0 while busy and 1 once ready. While busy, start bits are ignored. No status appears if nothing was started.
- R9: Within three system clocks of select going low, data out is disabled and any partial instruction is dropped. A running busy period still completes.
- R10: After an instruction other than read completes, rising edges with data-in low are ignored, and a new start bit in the same select period begins a new instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Select, active high |
| sck | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out / ready-busy level |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The bench reads each word back after writing it. A design with the wrong opcode or sub-code mapping, or one that drops the leading zero, returns words shifted by a bit. It also reads across the top address: a counter that saturates, or stops after one word, shows the wrong second word. It cuts a write short, issues writes while locked and polls status after each case. A design that executes short frames, ignores the enable latch or shows status with nothing pending is caught there. It also checks that write-all is still busy at a point where a single write has long finished, which exposes a missing erase phase.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_READ  = 2'd2
    } eep_state_e;

    typedef enum logic [1:0] {
        OP_MISC  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } eep_op_e;

    // sub-codes carried in the two address MSBs of the misc opcode
    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_WIPE   = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sck_rise,
    output logic cs_rise
);
    // bit 2 = cs, bit 1 = sck, bit 0 = di
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [2:0] q;
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q <= '0;
                    else        q <= {cs, sck, di};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q <= '0;
                    else        q <= g_stage[g-1].q;
                end
            end
        end
    endgenerate

    logic [2:0] last;
    logic [2:0] prev_q;
    assign last = g_stage[STAGES-1].q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= last;
    end

    assign cs_s     = last[2];
    assign di_s     = last[0];
    assign sck_rise = last[1] & ~prev_q[1];
    assign cs_rise  = last[2] & ~prev_q[2];
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_op,
    output logic busy
);
    localparam int CNTW = $clog2(2 * CYCLES + 1);

    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = long_op ? CNTW'(2 * CYCLES) : CNTW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          we_all,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < WORDS; i++)
                if (we_all || (we && waddr == AW'(i))) mem_q[i] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter bit WORD16      = 1'b0,
    parameter int PROG_CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic di,
    output logic dout,
    output logic dout_oe
);
    localparam int DW   = WORD16 ? 16 : 8;
    localparam int AW   = WORD16 ? 6 : 7;
    localparam int HDR  = 2 + AW;
    localparam int FULL = HDR + DW;
    localparam int CW   = $clog2(FULL + 1);
    localparam int BW   = $clog2(DW);

    typedef struct packed {
        eep_state_e    state;
        logic [CW-1:0] cnt;
        logic [FULL-1:0] sreg;
        logic [AW-1:0] addr;
        logic [DW-1:0] oshift;
        logic [BW-1:0] obit;
        logic          rd_oe;
        logic          rd_bit;
        logic          wen;
        logic          pend;
        logic          stat;
    } ctl_t;

    ctl_t r_d, r_q;

    logic cs_s, di_s, sck_rise, cs_rise;
    logic busy;
    logic prog_start, prog_long;
    logic we, we_all;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] wdata, rdata;
    logic [FULL-1:0] shifted;
    logic [CW-1:0] cnt_inc;
    eep_op_e op_hdr, op_full;
    logic [1:0] sub;

    eep_pin_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di),
        .cs_s(cs_s), .di_s(di_s), .sck_rise(sck_rise), .cs_rise(cs_rise)
    );

    eep_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .long_op(prog_long), .busy(busy)
    );

    eep_array #(.AW(AW), .DW(DW)) i_array (
        .clk(clk), .rst_n(rst_n), .we(we), .we_all(we_all), .waddr(waddr),
        .wdata(wdata), .raddr(raddr), .rdata(rdata)
    );

    assign shifted = {r_q.sreg[FULL-2:0], di_s};
    assign cnt_inc = r_q.cnt + 1'b1;
    assign op_hdr  = eep_op_e'(shifted[HDR-1 -: 2]);
    assign op_full = eep_op_e'(shifted[FULL-1 -: 2]);
    assign sub     = shifted[AW-1 -: 2];
    // header edge reads the fresh address; a streaming read fetches the next one
    assign raddr   = (r_q.state == ST_SHIFT) ? shifted[AW-1:0] : r_q.addr + 1'b1;

    always_comb begin
        r_d        = r_q;
        prog_start = 1'b0;
        prog_long  = 1'b0;
        we         = 1'b0;
        we_all     = 1'b0;
        waddr      = r_q.addr;
        wdata      = '1;

        if (!cs_s) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
            r_d.rd_oe = 1'b0;
            r_d.stat  = 1'b0;
        end else begin
            if (cs_rise && r_q.pend) r_d.stat = 1'b1;
            case (r_q.state)
                ST_IDLE: begin
                    if (sck_rise && di_s && !busy) begin
                        r_d.state = ST_SHIFT;
                        r_d.cnt   = '0;
                        r_d.sreg  = '0;
                        r_d.stat  = 1'b0;
                        r_d.pend  = 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (sck_rise) begin
                        r_d.sreg = shifted;
                        r_d.cnt  = cnt_inc;
                        if (cnt_inc == CW'(HDR)) begin
                            r_d.addr  = shifted[AW-1:0];
                            r_d.state = ST_IDLE;
                            case (op_hdr)
                                OP_READ: begin
                                    r_d.state  = ST_READ;
                                    r_d.rd_oe  = 1'b1;
                                    r_d.rd_bit = 1'b0;
                                    r_d.oshift = rdata;
                                    r_d.obit   = '0;
                                end
                                OP_ERASE: begin
                                    if (r_q.wen) begin
                                        prog_start = 1'b1;
                                        we         = 1'b1;
                                        waddr      = shifted[AW-1:0];
                                        r_d.pend   = 1'b1;
                                    end
                                end
                                OP_WRITE: r_d.state = ST_SHIFT;
                                default: begin
                                    case (sub)
                                        SUB_UNLOCK: r_d.wen = 1'b1;
                                        SUB_LOCK:   r_d.wen = 1'b0;
                                        SUB_WIPE: begin
                                            if (r_q.wen) begin
                                                prog_start = 1'b1;
                                                we_all     = 1'b1;
                                                r_d.pend   = 1'b1;
                                            end
                                        end
                                        default: r_d.state = ST_SHIFT;
                                    endcase
                                end
                            endcase
                        end else if (cnt_inc == CW'(FULL)) begin
                            r_d.state = ST_IDLE;
                            if (r_q.wen) begin
                                prog_start = 1'b1;
                                r_d.pend   = 1'b1;
                                wdata      = shifted[DW-1:0];
                                if (op_full == OP_WRITE) begin
                                    we = 1'b1;
                                end else begin
                                    we_all    = 1'b1;
                                    prog_long = 1'b1;
                                end
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (sck_rise) begin
                        r_d.rd_bit = r_q.oshift[DW-1];
                        r_d.oshift = {r_q.oshift[DW-2:0], 1'b0};
                        r_d.obit   = r_q.obit + 1'b1;
                        if (r_q.obit == BW'(DW - 1)) begin
                            r_d.obit   = '0;
                            r_d.addr   = r_q.addr + 1'b1;
                            r_d.oshift = rdata;
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout    = r_q.stat ? ~busy : r_q.rd_bit;
    assign dout_oe = r_q.rd_oe | r_q.stat;

    // observation points for the bound checker
    eep_state_e    st_w;
    logic          wen_w, stat_w;
    logic [AW-1:0] addr_w;
    assign st_w   = r_q.state;
    assign wen_w  = r_q.wen;
    assign stat_w = r_q.stat;
    assign addr_w = r_q.addr;
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
    import eep_pkg::*;
#(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          dout_oe,
    input eep_state_e    state,
    input logic          busy,
    input logic          wen,
    input logic          stat,
    input logic [AW-1:0] addr
);
    AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !$past(cs) && !$past(cs, 2) && !$past(cs, 3)) |-> !dout_oe); // R9

    AST_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (state == ST_READ || stat)); // R3

    AST_PROG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wen); // R5

    AST_BUSY_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state == ST_IDLE) |=> (state == ST_IDLE)); // R8

    AST_SEQ_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state == ST_READ) && addr != $past(addr))
        |-> (addr == AW'($past(addr) + 1'b1))); // R4
endmodule

bind eep_slave eep_slave_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .dout_oe(dout_oe), .state(st_w),
    .busy(busy), .wen(wen_w), .stat(stat_w), .addr(addr_w)
);

// File: tb/test_eep_slave.sv
module test_eep_slave;
    localparam int AW   = 7;
    localparam int DW   = 8;
    localparam int PROG = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, di = 1'b0;
    logic dout, dout_oe;
    int total = 0, bad = 0;
    logic [DW-1:0] w0, w1;

    always #10 clk = ~clk;

    eep_slave #(.WORD16(1'b0), .PROG_CYCLES(PROG)) i_eep_slave (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di),
        .dout(dout), .dout_oe(dout_oe)
    );

    // write/read-back vectors: {addr, data}
    localparam logic [AW+DW-1:0] VEC [6] = '{
        {7'd0,   8'h12}, {7'd1,  8'h80}, {7'd127, 8'h01},
        {7'd64,  8'hFE}, {7'd33, 8'h5A}, {7'd2,   8'h00}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        di = b; wclk(4);
        sck = 1'b1; wclk(4);
        sck = 1'b0; wclk(4);
    endtask

    task automatic sel();
        cs = 1'b1; wclk(6);
    endtask

    task automatic desel();
        cs = 1'b0; di = 1'b0; wclk(6);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a);
        send_bit(1'b1);
        send_bit(op[1]); send_bit(op[0]);
        for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic send_data(input logic [DW-1:0] d);
        for (int i = DW - 1; i >= 0; i--) send_bit(d[i]);
    endtask

    task automatic get_word(output logic [DW-1:0] w);
        w = '0;
        for (int i = 0; i < DW; i++) begin
            send_bit(1'b0);
            w = {w[DW-2:0], dout};
        end
    endtask

    task automatic wait_ready(input string req);
        int n;
        n = 0;
        sel();
        while (!(dout_oe === 1'b1 && dout === 1'b1) && n < 400) begin
            wclk(1); n++;
        end
        chk(req, int'(n < 400), 1);
        desel();
    endtask

    task automatic unlock();
        sel(); cmd(2'b00, 7'b1100000); desel();
    endtask

    task automatic lock();
        sel(); cmd(2'b00, 7'b0000000); desel();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        sel(); cmd(2'b01, a); send_data(d); desel();
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] w, input string req);
        sel(); cmd(2'b10, a);
        chk({req, " dummy oe"}, int'(dout_oe), 1);
        chk({req, " dummy zero"}, int'(dout), 0);
        get_word(w);
        desel();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        // reset: output disabled, array erased
        chk("R3 reset oe", int'(dout_oe), 0);
        rd(7'd5, w0, "R6 erased after reset");
        chk("R6 erased after reset", int'(w0), 8'hFF);

        // locked: write ignored and no status
        wr(7'd5, 8'h3C);
        sel();
        chk("R8 no status when nothing started", int'(dout_oe), 0);
        desel();
        rd(7'd5, w0, "R5 locked write");
        chk("R5 locked write ignored", int'(w0), 8'hFF);

        unlock();

        // first write: status shows busy, then ready
        wr(7'd9, 8'h11);
        sel();
        chk("R8 status oe", int'(dout_oe), 1);
        chk("R8 busy level", int'(dout), 0);
        desel();
        wait_ready("R8 ready");
        rd(7'd9, w0, "R6 write");
        chk("R6 write 9", int'(w0), 8'h11);

        // vector table
        for (int k = 0; k < 6; k++) begin
            wr(VEC[k][AW+DW-1 -: AW], VEC[k][DW-1:0]);
            wait_ready("R8 ready vec");
            rd(VEC[k][AW+DW-1 -: AW], w0, "R3 vec read");
            chk("R6 vec readback", int'(w0), int'(VEC[k][DW-1:0]));
        end

        // R4 sequential read wraps 127 -> 0
        sel(); cmd(2'b10, 7'd127);
        get_word(w0); get_word(w1);
        desel();
        chk("R4 seq word0", int'(w0), 8'h01);
        chk("R4 seq wrap word1", int'(w1), 8'h12);

        // R1: leading zero clocks before start
        sel();
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        cmd(2'b10, 7'd33);
        chk("R1 dummy after idle clocks", int'(dout_oe), 1);
        get_word(w0);
        desel();
        chk("R1 read after idle clocks", int'(w0), 8'h5A);

        // R9 aborted frame stores nothing
        sel();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        desel();
        chk("R9 oe after deselect", int'(dout_oe), 0);
        rd(7'd0, w0, "R9 after abort");
        chk("R9 abort kept word", int'(w0), 8'h12);

        // R10: idle clocks after an instruction, then a new start in same select
        sel();
        cmd(2'b00, 7'b1100000);
        send_bit(1'b0); send_bit(1'b0);
        cmd(2'b01, 7'd10); send_data(8'h77);
        desel();
        wait_ready("R10 ready");
        rd(7'd10, w0, "R10 chained");
        chk("R10 chained write", int'(w0), 8'h77);

        // R6 erase single word
        sel(); cmd(2'b11, 7'd10); desel();
        wait_ready("R6 erase ready");
        rd(7'd10, w0, "R6 erase");
        chk("R6 erase sets ones", int'(w0), 8'hFF);

        // R7 write-all: longer busy, erases zeros first
        sel(); cmd(2'b00, 7'b0100000); send_data(8'hA5); desel();
        sel();
        wclk(PROG);
        chk("R7 still busy past single write time", int'(dout), 0);
        desel();
        wait_ready("R7 ready");
        rd(7'd2, w0, "R7 fill");
        chk("R7 fill over zeros", int'(w0), 8'hA5);
        rd(7'd127, w0, "R7 fill");
        chk("R7 fill top", int'(w0), 8'hA5);

        // R6 erase-all
        sel(); cmd(2'b00, 7'b1000000); desel();
        wait_ready("R6 wipe ready");
        rd(7'd64, w0, "R6 wipe");
        chk("R6 wipe sets ones", int'(w0), 8'hFF);

        // R2 short write frame (one data bit missing)
        sel(); cmd(2'b01, 7'd20);
        for (int i = 0; i < DW - 1; i++) send_bit(1'b0);
        desel();
        sel();
        chk("R2 short frame no status", int'(dout_oe), 0);
        desel();
        rd(7'd20, w0, "R2 short");
        chk("R2 short frame stores nothing", int'(w0), 8'hFF);

        // R5 lock again: erase-all and write ignored
        wr(7'd20, 8'h00); wait_ready("R5 ready");
        lock();
        sel(); cmd(2'b00, 7'b1000000); desel();
        sel();
        chk("R5 locked wipe no status", int'(dout_oe), 0);
        desel();
        rd(7'd20, w0, "R5 locked");
        chk("R5 locked wipe ignored", int'(w0), 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule